// File: doc/BRIEF.md
# Two-Channel Interval Timer

This block is a small programmable interval timer with two counters, numbered 0 and 2, on a byte-wide register bus. Software first writes a control byte to pick a counter and its mode. It then writes the 16-bit count as two data bytes, low byte first. The counters only move on cycles where `tick_en` is high. That enable marks the nominal 1,193,180 Hz timer input rate, so one interval lasts the loaded count times one input period.

Each counter has two modes. In one-shot mode (mode 0) it fires once, sets a terminal flag and stops. In any other mode it reloads the same count and fires again and again. Each counter has its own expiry pulse. The status byte of counter 2 can be read back at the control address. A control word that names an unsupported counter or access mode raises a one-cycle error flag and is otherwise dropped.

Top module: `pit2ch_timer`

## Requirements
- R1: After reset, `expire` and `cfg_err` are 0, a status read returns 0, the next data byte is taken as a low byte, and both counters are idle in mode 0.
- R2: A write to the control address (3) whose bits 7:6 are 00 (counter 0, data port 0) or 10 (counter 2, data port 2) and whose bits 5:4 are 11 sets that counter's mode to bits 3:1 and raises no error.
- R3: A control write whose bits 7:6 are 01 or 11 drives `cfg_err` high for exactly the one clock after the write and changes no mode.
- R4: A control write whose bits 5:4 are not 11 drives `cfg_err` high for exactly one clock and changes no mode.
- R5: Data writes alternate low byte and high byte through one byte-phase flag shared by both data ports. Only the high-byte write starts a counter: the one at the port written. Its count is {high, last low}, even when the low byte went to the other port.
- R6: Counter 0 drives `expire[0]` and counter 2 drives `expire[1]`. With count N, the expiry pulse is high during the clock after the N-th `tick_en` edge that follows the load. A count of 0 means 65536.
- R7: In mode 0, expiry gives one pulse, stops the counter and sets bit 5 (value 0x20) of its status byte.
- R8: In any mode other than 0, the counter reloads on expiry and pulses every N enabled ticks.
- R9: The high-byte write that starts a counter clears its status byte.
- R10: A read at the control address returns counter 2's status byte. Counter 0's flag never shows there. Reads at other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer input-rate enable, one per input period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0, 2 data; 3 control/status) |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| expire | output | 2 | Expiry pulses: bit 0 counter 0, bit 1 counter 2 |
| cfg_err | output | 1 | One-cycle flag for a rejected control word |

## Verification
The embedded properties watch a few rules on every cycle:
- an expiry pulse follows an enabled tick;
- a terminal flag rises only together with its pulse;
- a load leaves the counter running with a clear flag and the byte phase back at low;
- an error follows only a control write;
- at most one mode register is written per control word.

Only the bench scenarios can show the rest. These are the exact interval lengths, including the 65536 case, and the periodic reload spacing. They also cover the way a low byte sent to one port joins a high byte sent to the other, that rejected control words leave the mode untouched, and which status appears on a read.

// File: rtl/pit2_pkg.sv
package pit2_pkg;
   localparam int BYTE_W = 8;
   localparam logic [1:0] SEL_CH0  = 2'b00;
   localparam logic [1:0] SEL_CH2  = 2'b10;
   localparam logic [1:0] ACC_LOHI = 2'b11;
   localparam logic [2:0] MODE_ONESHOT = 3'd0;

   typedef struct packed {
      logic [1:0] sel;
      logic [1:0] acc;
      logic [2:0] mode;
      logic       bcd;
   } ctl_word_t;

   function automatic logic is_oneshot(input logic [2:0] m);
      return m == MODE_ONESHOT;
   endfunction
endpackage

// File: rtl/pit2_ctl_decode.sv
module pit2_ctl_decode
   import pit2_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_ctl,
   input  logic [BYTE_W-1:0]   wdata,
   output logic [1:0]          mode_we,
   output logic [2:0]          mode_val,
   output logic                bad
);
   ctl_word_t word;
   assign word = ctl_word_t'(wdata);

   always_comb begin
      mode_we  = '0;
      bad      = 1'b0;
      mode_val = word.mode;
      if (wr_ctl) begin
         if (word.acc != ACC_LOHI) begin
            bad = 1'b1;
         end else begin
            case (word.sel)
               SEL_CH0: mode_we[0] = 1'b1;
               SEL_CH2: mode_we[1] = 1'b1;
               default: bad = 1'b1;
            endcase
         end
      end
   end

   // R2: one control word writes at most one mode register
   assert_one_mode_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mode_we));
endmodule

// File: rtl/pit2_byte_loader.sv
module pit2_byte_loader
   import pit2_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_data,
   input  logic [BYTE_W-1:0]   wdata,
   output logic                load,
   output logic [2*BYTE_W-1:0] count
);
   logic              hi_next_q;
   logic [BYTE_W-1:0] lo_q;

   assign load  = wr_data && hi_next_q;
   assign count = {wdata, lo_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_next_q <= 1'b0;
         lo_q      <= '0;
      end else if (wr_data) begin
         if (!hi_next_q) lo_q <= wdata;
         hi_next_q <= !hi_next_q;
      end
   end

   // R5: a completed load always returns the shared phase to the low byte
   assert_phase_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !hi_next_q);
endmodule

// File: rtl/pit2_counter.sv
module pit2_counter
   import pit2_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int TERM_BIT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              mode_we,
   input  logic [2:0]        mode_in,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_val,
   output logic              expire,
   output logic [BYTE_W-1:0] status
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [2:0]       mode_q;
   logic [CNT_W-1:0] reload_q, remain_q;
   logic             run_q, term_q, expire_q;
   logic             at_end;

   assign at_end = run_q && tick && (remain_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= MODE_ONESHOT;
         reload_q <= '0;
         remain_q <= '0;
         run_q    <= 1'b0;
         term_q   <= 1'b0;
         expire_q <= 1'b0;
      end else begin
         if (mode_we) mode_q <= mode_in;
         expire_q <= !load && at_end;
         if (load) begin
            reload_q <= load_val;
            remain_q <= load_val;
            run_q    <= 1'b1;
            term_q   <= 1'b0;
         end else if (run_q && tick) begin
            if (remain_q == ONE) begin
               if (is_oneshot(mode_q)) begin
                  run_q  <= 1'b0;
                  term_q <= 1'b1;
               end else begin
                  remain_q <= reload_q;
               end
            end else begin
               remain_q <= remain_q - ONE;
            end
         end
      end
   end

   assign expire = expire_q;

   always_comb begin
      status           = '0;
      status[TERM_BIT] = term_q;
   end

   // R6: an expiry pulse only follows an enabled tick edge
   assert_expire_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      expire_q |-> $past(tick));
   // R7: the terminal flag rises together with the expiry pulse
   assert_term_with_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(term_q) |-> expire_q);
   // R9: a start leaves the counter running with a clear flag
   assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (run_q && !term_q));
endmodule

// File: rtl/pit2ch_timer.sv
module pit2ch_timer
   import pit2_pkg::*;
#(
   parameter int ADDR_W    = 2,
   parameter int CH0_ADDR  = 0,
   parameter int CH2_ADDR  = 2,
   parameter int CTRL_ADDR = 3,
   parameter int TERM_BIT  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic [1:0]        expire,
   output logic              cfg_err
);
   localparam int NUM_CH = 2;
   localparam int CNT_W  = 2 * BYTE_W;
   localparam logic [ADDR_W-1:0] A_CH0  = ADDR_W'(CH0_ADDR);
   localparam logic [ADDR_W-1:0] A_CH2  = ADDR_W'(CH2_ADDR);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

   if (CH0_ADDR == CH2_ADDR || CTRL_ADDR == CH0_ADDR || CTRL_ADDR == CH2_ADDR) begin : g_bad_map
      $error("register addresses must be distinct");
   end
   if (CTRL_ADDR >= (1 << ADDR_W) || CH0_ADDR >= (1 << ADDR_W) || CH2_ADDR >= (1 << ADDR_W)) begin : g_bad_aw
      $error("register address does not fit ADDR_W");
   end
   if (TERM_BIT < 0 || TERM_BIT >= BYTE_W) begin : g_bad_term
      $error("TERM_BIT outside the status byte");
   end

   logic              wr_ctl, wr_data, ld_any, bad;
   logic [1:0]        mode_we;
   logic [2:0]        mode_val;
   logic [CNT_W-1:0]  ld_count;
   logic [BYTE_W-1:0] stat [NUM_CH];
   logic              err_q;

   assign wr_ctl  = bus_wr && (bus_addr == A_CTRL);
   assign wr_data = bus_wr && (bus_addr == A_CH0 || bus_addr == A_CH2);

   pit2_ctl_decode u_dec (
      .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wdata(bus_wdata),
      .mode_we(mode_we), .mode_val(mode_val), .bad(bad)
   );

   pit2_byte_loader u_ld (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wdata(bus_wdata),
      .load(ld_any), .count(ld_count)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      localparam logic [ADDR_W-1:0] MY_ADDR = (g == 0) ? A_CH0 : A_CH2;
      logic my_load;
      assign my_load = ld_any && (bus_addr == MY_ADDR);
      pit2_counter #(.CNT_W(CNT_W), .TERM_BIT(TERM_BIT)) u_cnt (
         .clk(clk), .rst_n(rst_n), .tick(tick_en),
         .mode_we(mode_we[g]), .mode_in(mode_val),
         .load(my_load), .load_val(ld_count),
         .expire(expire[g]), .status(stat[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= bad;
   end

   assign cfg_err   = err_q;
   assign bus_rdata = (bus_addr == A_CTRL) ? stat[NUM_CH-1] : '0;

   // R3: an error flag only ever follows a control-address write
   assert_err_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $past(bus_wr && bus_addr == A_CTRL));
endmodule

// File: tb/sim_pit2ch_timer.sv
module sim_pit2ch_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic [1:0] expire;
   logic       cfg_err;
   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pit2ch_timer u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .expire(expire), .cfg_err(cfg_err)
   );

   typedef struct packed {
      logic [0:0]  bit_idx;
      logic [7:0]  ctl;
      logic [1:0]  port;
      logic [15:0] cnt;
      logic [15:0] run;
      logic [15:0] first;
      logic [15:0] pulses;
      logic [7:0]  status;
   } vec_t;

   // R7/R8/R10 vectors: counter 0 entries first so counter 2 status stays 0
   localparam vec_t TBL [6] = '{
      '{1'b0, 8'h30, 2'd0, 16'd4, 16'd12, 16'd4, 16'd1, 8'h00},
      '{1'b0, 8'h34, 2'd0, 16'd3, 16'd10, 16'd3, 16'd3, 8'h00},
      '{1'b0, 8'h36, 2'd0, 16'd1, 16'd5,  16'd1, 16'd5, 8'h00},
      '{1'b1, 8'hB0, 2'd2, 16'd7, 16'd20, 16'd7, 16'd1, 8'h20},
      '{1'b1, 8'hB4, 2'd2, 16'd5, 16'd16, 16'd5, 16'd3, 8'h00},
      '{1'b1, 8'hB0, 2'd2, 16'd2, 16'd6,  16'd2, 16'd1, 8'h20}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d, output logic err);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      err = cfg_err;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic run_ticks(input int b, input int n, output int first, output int pulses,
                            output int other);
      first = 0; pulses = 0; other = 0;
      tick_en = 1'b1;
      for (int i = 1; i <= n; i++) begin
         @(negedge clk);
         if (expire[b]) begin
            pulses++;
            if (first == 0) first = i;
         end
         if (expire[1-b]) other++;
         if (i == n) tick_en = 1'b0;
      end
   endtask

   task automatic load(input logic [1:0] port, input logic [7:0] ctl, input int cnt);
      logic e;
      bus_write(2'd3, ctl, e);
      bus_write(port, cnt[7:0], e);
      bus_write(port, cnt[15:8], e);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic e;
      int f, p, o;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 expire", expire, 0);
      chk("R1 cfg_err", cfg_err, 0);
      rd(2'd3, v); chk("R1 status", v, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 expire after release", expire, 0);

      foreach (TBL[k]) begin
         load(TBL[k].port, TBL[k].ctl, TBL[k].cnt);
         run_ticks(TBL[k].bit_idx, TBL[k].run, f, p, o);
         chk($sformatf("R6 first expiry vec%0d", k), f, TBL[k].first);
         chk($sformatf("R7/R8 pulse count vec%0d", k), p, TBL[k].pulses);
         rd(2'd3, v);
         chk($sformatf("R10 status read vec%0d", k), v, TBL[k].status);
      end

      // R2 stop counter 0: one-shot count 1
      load(2'd0, 8'h30, 1);
      run_ticks(0, 3, f, p, o);
      chk("R2 counter0 one-shot pulses", p, 1);

      // R9 start clears status; R5 low byte alone does not start
      bus_write(2'd3, 8'hB0, e);
      chk("R2 valid word no error", e, 0);
      bus_write(2'd2, 8'h03, e);
      rd(2'd3, v); chk("R5 low byte keeps old status", v, 8'h20);
      bus_write(2'd2, 8'h00, e);
      rd(2'd3, v); chk("R9 status cleared on start", v, 8'h00);
      run_ticks(1, 10, f, p, o);
      chk("R6 count3 first", f, 3);
      rd(2'd3, v); chk("R7 status set", v, 8'h20);

      // R5 shared phase: low via port 0, high via port 2
      bus_write(2'd0, 8'h04, e);
      run_ticks(1, 10, f, p, o);
      chk("R5 no start on low byte", p + o, 0);
      bus_write(2'd2, 8'h00, e);
      run_ticks(1, 10, f, p, o);
      chk("R5 cross-port count first", f, 4);
      chk("R5 counter0 untouched", o, 0);

      // R3/R4 rejected words leave counter 2 in periodic mode
      bus_write(2'd3, 8'hB4, e);
      chk("R2 periodic word no error", e, 0);
      bus_write(2'd3, 8'h70, e);
      chk("R3 select 01 error", e, 1);
      @(negedge clk);
      chk("R3 error one clock", cfg_err, 0);
      bus_write(2'd3, 8'hF0, e);
      chk("R3 select 11 error", e, 1);
      bus_write(2'd3, 8'h80, e);
      chk("R4 access 00 error", e, 1);
      bus_write(2'd3, 8'hA0, e);
      chk("R4 access 10 error", e, 1);
      @(negedge clk);
      chk("R4 error one clock", cfg_err, 0);
      bus_write(2'd2, 8'h03, e);
      bus_write(2'd2, 8'h00, e);
      run_ticks(1, 10, f, p, o);
      chk("R3 R4 mode unchanged periodic pulses", p, 3);

      // R6 count 0 means 65536
      load(2'd2, 8'hB0, 0);
      run_ticks(1, 65540, f, p, o);
      chk("R6 count0 first", f, 65536);
      chk("R6 count0 pulses", p, 1);

      // R10 other address reads zero
      rd(2'd0, v); chk("R10 data port read", v, 0);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule